// File: doc/BRIEF.md
# Iterative Integer Multiply-Accumulate Unit

This block performs integer multiplication for a 32-bit processor datapath. A single 33-bit by 9-bit signed partial-product row forms one term per clock. Each term covers one 8-bit slice of the second operand. The row is applied four times, least significant slice first. Every term is added into a 64-bit running sum at the slice's bit offset. The running sum starts from zero, from a 32-bit addend, or from a 64-bit addend, depending on the operation. The same datapath therefore produces truncated 32-bit products, signed and unsigned 64-bit products, and their accumulate forms.

A caller presents an operation code, two operands, the addend words and a flag-update request together with a one-cycle `start` pulse. Four cycles later the block raises `done` for one cycle. The result words and the negative and zero flags are then valid, and they stay unchanged until the next operation completes. A `start` that arrives while an operation is in progress is dropped.

Top module: `imac_unit`

## Requirements
- R1: Operation code 0 returns the low 32 bits of `src_a*src_b` on `res_lo`, and `res_hi` is 0.
- R2: Operation code 1 returns the low 32 bits of `src_a*src_b + acc_lo` on `res_lo`, and `res_hi` is 0.
- R3: Operation code 2 returns the full 64-bit unsigned product of the two operands, with bits 31..0 on `res_lo` and bits 63..32 on `res_hi`.
- R4: Operation code 4 returns the full 64-bit product with both operands taken as two's-complement signed values.
- R5: Operation codes 3 (unsigned) and 5 (signed) add the 64-bit value {`acc_hi`,`acc_lo`} to the 64-bit product, modulo 2^64.
- R6: Operation codes 6 and 7 behave exactly like code 0, and they ignore `acc_lo` and `acc_hi`.
- R7: When `start` is sampled high while the unit is idle, `done` is high during the fourth cycle after that sampling edge. It stays high for exactly one cycle.
- R8: A `start` sampled while an operation is in progress produces no extra `done` and does not alter the result of the running operation.
- R9: For 64-bit results (codes 2 to 5) with `set_flags` high, `flag_n` equals bit 63 of the result, and `flag_z` is 1 only when all 64 bits are zero.
- R10: For 32-bit results (codes 0, 1, 6, 7) with `set_flags` high, `flag_n` equals bit 31, and `flag_z` is 1 only when `res_lo` is zero.
- R11: With `set_flags` low at start, `flag_n` and `flag_z` keep their previous values when the operation completes.
- R12: After reset, `done`, `res_lo`, `res_hi`, `flag_n` and `flag_z` are all 0.
- R13: `res_lo` and `res_hi` change only at the edge that raises `done`, and they hold their values in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 3 | Operation code, see R1 to R6 |
| set_flags | input | 1 | Update N and Z on completion |
| src_a | input | 32 | Multiplicand |
| src_b | input | 32 | Multiplier, consumed 8 bits per cycle |
| acc_lo | input | 32 | Addend low word (codes 1, 3, 5) |
| acc_hi | input | 32 | Addend high word (codes 3, 5) |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result bits 31..0 |
| res_hi | output | 32 | Result bits 63..32 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
Any fault in the slice counter, the operand shift register or the sign handling of the last slice shows up at the ports no later than the `done` cycle. Such a fault appears either as a `done` pulse at the wrong cycle or as a wrong value in one of the two result words. A missing sign extension of the top slice only corrupts the high word of signed operations whose multiplier is negative, so those cases are driven on purpose. A corrupted hold path for the result or flag registers would instead show as outputs changing in idle cycles.

// File: rtl/imac_pkg.sv
package imac_pkg;

  typedef enum logic [2:0] {
    OP_MUL   = 3'd0,
    OP_MLA   = 3'd1,
    OP_UMULL = 3'd2,
    OP_UMLAL = 3'd3,
    OP_SMULL = 3'd4,
    OP_SMLAL = 3'd5
  } imac_op_e;

  typedef enum logic [1:0] {
    ADD_NONE  = 2'd0,
    ADD_SHORT = 2'd1,
    ADD_LONG  = 2'd2
  } imac_add_e;

  typedef struct packed {
    logic      wide;  // 64-bit result
    logic      sgn;   // signed operands
    imac_add_e add;   // addend selection
  } imac_ctl_t;

endpackage

// File: rtl/imac_opdec.sv
module imac_opdec
  import imac_pkg::*;
(
  input  logic [2:0] op_code,
  output imac_ctl_t  ctl
);

  always_comb begin
    ctl.wide = 1'b0;
    ctl.sgn  = 1'b0;
    ctl.add  = ADD_NONE;
    case (op_code)
      OP_MLA:   ctl.add = ADD_SHORT;
      OP_UMULL: ctl.wide = 1'b1;
      OP_UMLAL: begin
        ctl.wide = 1'b1;
        ctl.add  = ADD_LONG;
      end
      OP_SMULL: begin
        ctl.wide = 1'b1;
        ctl.sgn  = 1'b1;
      end
      OP_SMLAL: begin
        ctl.wide = 1'b1;
        ctl.sgn  = 1'b1;
        ctl.add  = ADD_LONG;
      end
      default: ;  // plain truncated multiply
    endcase
  end

endmodule

// File: rtl/imac_seq.sv
module imac_seq #(
  parameter int NSTEP = 4,
  localparam int IW   = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [IW-1:0] idx,
  output logic          done
);

  logic          busy_q, busy_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  assign accept = start & ~busy_q;
  assign last   = busy_q && (idx_q == IW'(NSTEP - 1));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign idx  = idx_q;
  assign done = done_q;

endmodule

// File: rtl/imac_pprow.sv
module imac_pprow #(
  parameter int AW    = 32,
  parameter int SW    = 8,
  parameter int RW    = 64,
  parameter int NSTEP = 4,
  localparam int IW   = (NSTEP > 1) ? $clog2(NSTEP) : 1,
  localparam int PW   = AW + SW + 2
) (
  input  logic [AW:0]   a_ext,
  input  logic [SW-1:0] slice,
  input  logic          slice_sgn,
  input  logic [IW-1:0] idx,
  output logic [RW-1:0] term
);

  logic signed [AW:0]   a_s;
  logic signed [SW:0]   s_s;
  logic signed [PW-1:0] prod;
  logic [RW-1:0]        base;
  logic [RW-1:0]        shifted [NSTEP];

  assign a_s  = a_ext;
  assign s_s  = {slice_sgn & slice[SW-1], slice};
  assign prod = PW'(a_s) * PW'(s_s);
  assign base = {{(RW - PW){prod[PW-1]}}, prod};

  for (genvar k = 0; k < NSTEP; k++) begin : g_shift
    assign shifted[k] = base << (k * SW);
  end

  assign term = shifted[idx];

endmodule

// File: rtl/imac_unit.sv
module imac_unit
  import imac_pkg::*;
#(
  parameter int DW    = 32,
  parameter int SW    = 8,
  localparam int NSTEP = DW / SW,
  localparam int RW    = 2 * DW,
  localparam int IW    = (NSTEP > 1) ? $clog2(NSTEP) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          set_flags,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] acc_lo,
  input  logic [DW-1:0] acc_hi,
  output logic          done,
  output logic [DW-1:0] res_lo,
  output logic [DW-1:0] res_hi,
  output logic          flag_n,
  output logic          flag_z
);

  imac_ctl_t     ctl_in, ctl_q, ctl_d;
  logic          accept, busy, last;
  logic [IW-1:0] idx;
  logic [DW:0]   a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  logic [RW-1:0] sum_q, sum_d, sum_next, term, init_val;
  logic [RW-1:0] res_q, res_d;
  logic          sf_q, sf_d;
  logic          fn_q, fn_d, fz_q, fz_d;
  logic          wide_run;

  imac_opdec u_dec (
    .op_code (op),
    .ctl     (ctl_in)
  );

  imac_seq #(.NSTEP(NSTEP)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .idx    (idx),
    .done   (done)
  );

  imac_pprow #(.AW(DW), .SW(SW), .RW(RW), .NSTEP(NSTEP)) u_row (
    .a_ext     (a_q),
    .slice     (b_q[SW-1:0]),
    .slice_sgn (ctl_q.sgn & last),
    .idx       (idx),
    .term      (term)
  );

  assign sum_next = sum_q + term;
  assign wide_run = ctl_q.wide;

  always_comb begin
    case (ctl_in.add)
      ADD_SHORT: init_val = {{DW{1'b0}}, acc_lo};
      ADD_LONG:  init_val = {acc_hi, acc_lo};
      default:   init_val = '0;
    endcase
  end

  // next-state
  always_comb begin
    ctl_d = ctl_q;
    a_d   = a_q;
    b_d   = b_q;
    sum_d = sum_q;
    sf_d  = sf_q;
    res_d = res_q;
    fn_d  = fn_q;
    fz_d  = fz_q;
    if (accept) begin
      ctl_d = ctl_in;
      a_d   = {ctl_in.sgn & src_a[DW-1], src_a};
      b_d   = src_b;
      sum_d = init_val;
      sf_d  = set_flags;
    end else if (busy) begin
      sum_d = sum_next;
      b_d   = b_q >> SW;
      if (last) begin
        if (ctl_q.wide) begin
          res_d = sum_next;
        end else begin
          res_d = {{DW{1'b0}}, sum_next[DW-1:0]};
        end
        if (sf_q) begin
          if (ctl_q.wide) begin
            fn_d = sum_next[RW-1];
            fz_d = (sum_next == '0);
          end else begin
            fn_d = sum_next[DW-1];
            fz_d = (sum_next[DW-1:0] == '0);
          end
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      sum_q <= '0;
      sf_q  <= 1'b0;
      res_q <= '0;
      fn_q  <= 1'b0;
      fz_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      a_q   <= a_d;
      b_q   <= b_d;
      sum_q <= sum_d;
      sf_q  <= sf_d;
      res_q <= res_d;
      fn_q  <= fn_d;
      fz_q  <= fz_d;
    end
  end

  assign res_lo = res_q[DW-1:0];
  assign res_hi = res_q[RW-1:DW];
  assign flag_n = fn_q;
  assign flag_z = fz_q;

endmodule

// File: rtl/imac_unit_chk.sv
module imac_unit_chk #(
  parameter int DW    = 32,
  parameter int NSTEP = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          busy,
  input logic          wide_run,
  input logic          sf_run,
  input logic [DW-1:0] res_lo,
  input logic [DW-1:0] res_hi,
  input logic          flag_n,
  input logic          flag_z
);

  localparam int CW = $clog2(NSTEP + 2) + 1;
  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else run_len <= '0;
  end

  assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_len == CW'(NSTEP)) && !busy);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_lo) && $stable(res_hi));

  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done || !sf_run) |-> $stable(flag_n) && $stable(flag_z));

  assert_short_high_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_run) |-> (res_hi == '0));

  assert_wide_zero_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wide_run && sf_run) |-> (flag_z == ((res_lo == '0) && (res_hi == '0))));

  assert_short_neg_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_run && sf_run) |-> (flag_n == res_lo[DW-1]));

endmodule

bind imac_unit imac_unit_chk #(.DW(DW), .NSTEP(NSTEP)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .done     (done),
  .busy     (busy),
  .wide_run (wide_run),
  .sf_run   (sf_q),
  .res_lo   (res_lo),
  .res_hi   (res_hi),
  .flag_n   (flag_n),
  .flag_z   (flag_z)
);

// File: tb/imac_unit_test.sv
`timescale 1ns/1ps
module imac_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        set_flags = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, acc_lo = '0, acc_hi = '0;
  logic        done, flag_n, flag_z;
  logic [31:0] res_lo, res_hi;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;
  logic [63:0] last_res = '0;

  logic [65:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  imac_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .set_flags(set_flags),
    .src_a(src_a), .src_b(src_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .done(done), .res_lo(res_lo), .res_hi(res_hi), .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R8 actual=unexpected done expected=no done");
      end else begin
        logic [65:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check64(t, {res_hi, res_lo}, e[63:0]);
        check64({t, " flags"}, {62'd0, flag_n, flag_z}, {62'd0, e[65:64]});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [63:0] model(input logic [2:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [31:0] lo,
                                        input logic [31:0] hi);
    logic [63:0] ua, ub, sa, sb, p;
    ua = {32'd0, a};
    ub = {32'd0, b};
    sa = {{32{a[31]}}, a};
    sb = {{32{b[31]}}, b};
    case (o)
      3'd1:    p = {32'd0, 32'(ua * ub + {32'd0, lo})};
      3'd2:    p = ua * ub;
      3'd3:    p = ua * ub + {hi, lo};
      3'd4:    p = sa * sb;
      3'd5:    p = sa * sb + {hi, lo};
      default: p = {32'd0, 32'(ua * ub)};
    endcase
    return p;
  endfunction

  // driver: issues one operation, checks done timing; optional intruding start
  task automatic run_op(input string req, input logic [2:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] lo, input logic [31:0] hi,
                        input logic sf, input bit intrude);
    logic [63:0] r;
    logic wide;
    r = model(o, a, b, lo, hi);
    wide = (o >= 3'd2) && (o <= 3'd5);
    if (sf) begin
      exp_n = wide ? r[63] : r[31];
      exp_z = wide ? (r == 64'd0) : (r[31:0] == 32'd0);
    end
    exp_q.push_back({exp_n, exp_z, r});
    tag_q.push_back(req);
    last_res = r;
    @(negedge clk);
    op = o; src_a = a; src_b = b; acc_lo = lo; acc_hi = hi; set_flags = sf; start = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (intrude && i == 2) begin
        op = 3'd2; src_a = 32'h1234_5678; src_b = 32'h9abc_def0;
        acc_lo = 32'h5555_5555; acc_hi = 32'haaaa_aaaa; set_flags = ~sf; start = 1'b1;
      end
      check64("R7 done early", {63'd0, done}, 64'd0);
    end
    @(negedge clk);
    check64("R7 done at fourth cycle", {63'd0, done}, 64'd1);
    @(negedge clk);
    check64("R7 done single cycle", {63'd0, done}, 64'd0);
    if (intrude) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check64("R8 no extra done", {63'd0, done}, 64'd0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check64("R12 reset outputs", {res_hi, res_lo}, 64'd0);
    check64("R12 reset done/flags", {61'd0, done, flag_n, flag_z}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R1 small mul", 3'd0, 32'd7, 32'd6, 32'd99, 32'd99, 1'b1, 1'b0);
    run_op("R1 wrap mul", 3'd0, 32'hffff_ffff, 32'hffff_ffff, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R10 short neg", 3'd0, 32'h4000_0000, 32'd2, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R10 short zero", 3'd0, 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R2 mla", 3'd1, 32'hdead_beef, 32'h0102_0304, 32'hffff_fff0, 32'h77, 1'b1, 1'b0);
    run_op("R3 umull max", 3'd2, 32'hffff_ffff, 32'hffff_ffff, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R9 long nonzero", 3'd2, 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R4 smull neg", 3'd4, 32'hffff_fffe, 32'd3, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R4 smull negb", 3'd4, 32'd12345, 32'h8000_0001, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R4 smull min", 3'd4, 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 1'b0);
    run_op("R5 umlal", 3'd3, 32'hcafe_f00d, 32'h8765_4321, 32'hffff_ffff, 32'hffff_fff0, 1'b1, 1'b0);
    run_op("R5 smlal", 3'd5, 32'hf000_0001, 32'h8123_4567, 32'h1111_2222, 32'h3333_4444, 1'b1, 1'b0);
    run_op("R9 long zero", 3'd5, 32'hffff_ffff, 32'd1, 32'd1, 32'd0, 1'b1, 1'b0);
    run_op("R6 code6", 3'd6, 32'h0000_1234, 32'h0000_5678, 32'hffff_ffff, 32'hffff_ffff, 1'b1, 1'b0);
    run_op("R6 code7", 3'd7, 32'h8000_0003, 32'hffff_fff1, 32'h1, 32'h1, 1'b1, 1'b0);
    run_op("R11 flags held", 3'd4, 32'hffff_ffff, 32'd5, 32'd0, 32'd0, 1'b0, 1'b0);
    run_op("R8 intruding start", 3'd1, 32'd1000, 32'd2000, 32'd3, 32'd0, 1'b1, 1'b1);

    repeat (10) @(negedge clk);
    check64("R13 result held", {res_hi, res_lo}, last_res);
    check64("R11 flags unchanged idle", {62'd0, flag_n, flag_z}, {62'd0, exp_n, exp_z});
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 actual=%0d pending expected=0 pending", exp_q.size());
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule